// File: doc/BRIEF.md
# Priority Trigger Sequence Engine

This block steps a power-management controller through command sequences chosen by trigger events. When its enable input goes high, it reads command memory from address zero up to the first END word. Along the way it fills a per-trigger table. Each table entry holds a start address or a fixed-state code, a preemption flag and a handoff flag. Setup words may also set the initial set of enabled triggers.

After loading, the engine waits for trigger events and services the lowest-numbered enabled pending trigger. To do so it fetches commands from that trigger's start address until it reaches END. A trigger marked immediate cuts short whatever sequence is running. All other triggers are latched and served in priority order once the running sequence ends. A trigger whose entry is flagged as a handoff runs no sequence. Instead, the engine presents the stored state code on an output and waits there until it is disabled.

Command memory uses a synchronous read: an address presented with a read strobe returns its word on the following cycle. Command side effects other than table setup, enable-set update and branching belong to other blocks.

Top module: `tseq_engine`

## Requirements
- R1: When `activeEn` rises, the engine reads addresses 0, 1, 2 and so on in order, one read every two cycles, up to and including the first END word. It then raises `tableReady` and issues no further reads until a trigger is serviced.
- R2: The 4-bit opcode is in bits [31:28]:
  - 0 is END.
  - 1 is a setup word: trigger ID in [27:23], immediate flag in [22], handoff flag in [21], target or state code in [7:0].
  - 2 is an enable-set word: bits [27:0] give the new enable vector, with bit n enabling trigger n.
  - Every other opcode, including 3, does nothing except advance the address.
- R3: When several enabled triggers are pending in idle, the lowest trigger ID is serviced first.
- R4: A serviced trigger's sequence is fetched from its table target in ascending address order up to and including END.
- R5: A non-immediate trigger that fires while a sequence runs does not interrupt it. It is serviced after that sequence's END.
- R6: An enabled immediate trigger that fires during a sequence abandons the command then being fetched. The engine's next read is the immediate trigger's target, and the abandoned sequence is not resumed.
- R7: An enable-set word replaces the enable vector. A pending trigger that is not enabled stays latched and produces no reads until a later enable-set word enables it, after which it is serviced.
- R8: Servicing a trigger whose handoff flag is set raises `fixedValid` with `fixedCode` equal to its stored code. No reads are issued, and further triggers are ignored while `activeEn` stays high.
- R9: Reset, or `activeEn` low, clears `tableReady`, `fixedValid`, the table, the enable vector and all pending latches. Trigger events while `activeEn` is low are discarded.
- R10: A trigger event is a 0-to-1 transition of its `trigIn` bit. A level held high is serviced once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| activeEn | input | 1 | High while the engine is in its active mode |
| trigIn | input | 28 | Trigger inputs, bit n is trigger ID n |
| memRd | output | 1 | Command memory read strobe |
| memAddr | output | 8 | Command memory address |
| memData | input | 32 | Command word, valid the cycle after `memRd` |
| tableReady | output | 1 | Table loaded, engine servicing triggers |
| fixedValid | output | 1 | Control handed to the fixed state machine |
| fixedCode | output | 8 | State code for the handoff |

## Verification
The bench logs every address the engine reads and compares that trace against the order the requirements predict. It sweeps every pair of trigger IDs fired together, so a reversed or off-by-one priority encoder would serve the pair in the wrong order or serve the wrong sequence. An immediate trigger is fired one cycle into a sequence: a design that waits for END would show the rest of the interrupted sequence in the trace, and one that resumes would show its tail afterwards. The bench also checks four other cases:
- A trigger pending while disabled must surface only after an enable-set word; a design that drops it would never fetch its sequence.
- A held trigger level must be serviced exactly once.
- A handoff trigger must issue no reads.
- Trigger events seen while disabled must not survive reactivation; a design that leaks them would show extra fetches after the reload.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  localparam logic [3:0] OP_END  = 4'h0;
  localparam logic [3:0] OP_SET  = 4'h1;
  localparam logic [3:0] OP_MASK = 4'h2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LD_ISSUE,
    ST_LD_EXEC,
    ST_IDLE,
    ST_RUN_ISSUE,
    ST_RUN_EXEC,
    ST_HANDOFF
  } state_e;

  typedef struct packed {
    logic clearAll;   // drop table, enable vector, pending latches, pc
    logic pcInc;      // advance to next command
    logic takeAny;    // service lowest enabled pending trigger
    logic takeImm;    // service lowest enabled pending immediate trigger
    logic tblWrite;   // setup word: write table entry
    logic maskWrite;  // enable-set word: replace enable vector
  } strobe_t;

endpackage

// File: rtl/tseq_dp.sv
module tseq_dp
  import tseq_pkg::*;
#(
  parameter int NUM_TRIG = 28,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic [DATA_W-1:0]   memData,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   fixedCode,
  output logic [3:0]          opcode,
  output logic                anyReady,
  output logic                immReady,
  output logic                anyFixed,
  output logic                immFixed
);

  localparam int ID_W    = $clog2(NUM_TRIG);
  localparam int ID_HI   = DATA_W - 5;
  localparam int IMM_BIT = DATA_W - 5 - ID_W;
  localparam int FIX_BIT = DATA_W - 6 - ID_W;

  logic [ADDR_W-1:0]   tblTarget [NUM_TRIG];
  logic [NUM_TRIG-1:0] tblImm, tblFix;
  logic [NUM_TRIG-1:0] maskReg, pend, trigPrev;
  logic [NUM_TRIG-1:0] rise, ready, immVec, clrVec;
  logic [ID_W-1:0]     bestId, immId, selId, setId;
  logic                take;

  function automatic logic [ID_W-1:0] lowestSet(input logic [NUM_TRIG-1:0] v);
    logic [ID_W-1:0] idx;
    idx = '0;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (v[i]) idx = ID_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [NUM_TRIG-1:0] belowId(input logic [ID_W-1:0] id);
    logic [NUM_TRIG-1:0] m;
    for (int i = 0; i < NUM_TRIG; i++) m[i] = (ID_W'(i) < id);
    return m;
  endfunction

  // command field decode
  assign opcode = memData[DATA_W-1 -: 4];
  assign setId  = memData[ID_HI -: ID_W];

  // trigger selection
  assign rise     = trigIn & ~trigPrev;
  assign ready    = pend & maskReg;
  assign immVec   = ready & tblImm;
  assign bestId   = lowestSet(ready);
  assign immId    = lowestSet(immVec);
  assign anyReady = |ready;
  assign immReady = |immVec;
  assign anyFixed = tblFix[bestId];
  assign immFixed = tblFix[immId];
  assign take     = stb.takeAny | stb.takeImm;
  assign selId    = stb.takeImm ? immId : bestId;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_clr
    assign clrVec[g] = take && (selId == ID_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= '0;
      pend     <= '0;
    end else begin
      trigPrev <= trigIn;
      if (stb.clearAll) pend <= '0;
      else              pend <= (pend & ~clrVec) | rise;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      tblImm  <= '0;
      tblFix  <= '0;
      for (int i = 0; i < NUM_TRIG; i++) tblTarget[i] <= '0;
    end else if (stb.clearAll) begin
      maskReg <= '0;
      tblImm  <= '0;
      tblFix  <= '0;
      for (int i = 0; i < NUM_TRIG; i++) tblTarget[i] <= '0;
    end else begin
      if (stb.maskWrite) maskReg <= memData[NUM_TRIG-1:0];
      if (stb.tblWrite && (setId < ID_W'(NUM_TRIG))) begin
        tblTarget[setId] <= memData[ADDR_W-1:0];
        tblImm[setId]    <= memData[IMM_BIT];
        tblFix[setId]    <= memData[FIX_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc        <= '0;
      fixedCode <= '0;
    end else if (stb.clearAll) begin
      pc        <= '0;
      fixedCode <= '0;
    end else if (take) begin
      pc <= tblTarget[selId];
      if (tblFix[selId]) fixedCode <= tblTarget[selId];
    end else if (stb.pcInc) begin
      pc <= pc + 1'b1;
    end
  end

  // the serviced trigger is enabled, pending, and nothing lower is ready
  assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeAny |-> (ready[bestId] && ((ready & belowId(bestId)) == '0)));

  assert_clear_on_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (pend == '0 && maskReg == '0 && tblFix == '0));

  // a disabled pending latch survives until disable or reset
  assert_masked_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clearAll |=> ((pend & $past(pend & ~maskReg)) == $past(pend & ~maskReg)));

  assert_edge_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clearAll && $past(trigIn[0]) && trigIn[0] && !pend[0]) |=> !pend[0]);

endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
  import tseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       activeEn,
  input  logic [3:0] opcode,
  input  logic       anyReady,
  input  logic       immReady,
  input  logic       anyFixed,
  input  logic       immFixed,
  output strobe_t    stb,
  output logic       memRd,
  output logic       tableReady,
  output logic       fixedValid
);

  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxt;
  end

  always_comb begin
    stb   = '0;
    memRd = 1'b0;
    nxt   = state;
    if (!activeEn) begin
      stb.clearAll = 1'b1;
      nxt          = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          stb.clearAll = 1'b1;
          nxt          = ST_LD_ISSUE;
        end
        ST_LD_ISSUE: begin
          memRd = 1'b1;
          nxt   = ST_LD_EXEC;
        end
        ST_IDLE: begin
          if (anyReady) begin
            stb.takeAny = 1'b1;
            nxt         = anyFixed ? ST_HANDOFF : ST_RUN_ISSUE;
          end
        end
        ST_RUN_ISSUE: begin
          if (immReady) begin
            stb.takeImm = 1'b1;
            nxt         = immFixed ? ST_HANDOFF : ST_RUN_ISSUE;
          end else begin
            memRd = 1'b1;
            nxt   = ST_RUN_EXEC;
          end
        end
        ST_LD_EXEC, ST_RUN_EXEC: begin
          if (state == ST_RUN_EXEC && immReady) begin
            stb.takeImm = 1'b1;
            nxt         = immFixed ? ST_HANDOFF : ST_RUN_ISSUE;
          end else if (opcode == OP_END) begin
            nxt = ST_IDLE;
          end else begin
            stb.pcInc     = 1'b1;
            stb.tblWrite  = (opcode == OP_SET);
            stb.maskWrite = (opcode == OP_MASK);
            nxt           = (state == ST_LD_EXEC) ? ST_LD_ISSUE : ST_RUN_ISSUE;
          end
        end
        ST_HANDOFF: nxt = ST_HANDOFF;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  assign fixedValid = (state == ST_HANDOFF);
  assign tableReady = (state == ST_IDLE) || (state == ST_RUN_ISSUE) ||
                      (state == ST_RUN_EXEC) || (state == ST_HANDOFF);

  assert_single_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  assert_preempt_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN_EXEC && immReady && activeEn) |=>
      (state == ST_RUN_ISSUE || state == ST_HANDOFF));

  assert_handoff_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fixedValid && activeEn) |=> (fixedValid && !memRd));

  assert_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !activeEn |=> (!tableReady && !fixedValid && !memRd));

endmodule

// File: rtl/tseq_engine.sv
module tseq_engine
  import tseq_pkg::*;
#(
  parameter int NUM_TRIG = 28,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                activeEn,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic                memRd,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W-1:0]   memData,
  output logic                tableReady,
  output logic                fixedValid,
  output logic [ADDR_W-1:0]   fixedCode
);

  strobe_t    stb;
  logic [3:0] opcode;
  logic       anyReady, immReady, anyFixed, immFixed;

  tseq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .activeEn   (activeEn),
    .opcode     (opcode),
    .anyReady   (anyReady),
    .immReady   (immReady),
    .anyFixed   (anyFixed),
    .immFixed   (immFixed),
    .stb        (stb),
    .memRd      (memRd),
    .tableReady (tableReady),
    .fixedValid (fixedValid)
  );

  tseq_dp #(
    .NUM_TRIG (NUM_TRIG),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .trigIn    (trigIn),
    .memData   (memData),
    .pc        (memAddr),
    .fixedCode (fixedCode),
    .opcode    (opcode),
    .anyReady  (anyReady),
    .immReady  (immReady),
    .anyFixed  (anyFixed),
    .immFixed  (immFixed)
  );

  assert_code_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fixedValid && activeEn) |=> $stable(fixedCode));

endmodule

// File: tb/test_tseq_engine.sv
module test_tseq_engine;

  localparam int CLK_PERIOD = 10;
  typedef int trace_t [8];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        activeEn = 1'b0;
  logic [27:0] trigIn = '0;
  logic        memRd;
  logic [7:0]  memAddr;
  logic [31:0] memData = '0;
  logic        tableReady, fixedValid;
  logic [7:0]  fixedCode;

  logic [31:0] mem [256];
  int          logA [64];
  int          logN = 0;
  int          nVec = 0;
  int          nBad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tseq_engine i_tseq_engine (
    .clk (clk), .rstN (rstN), .activeEn (activeEn), .trigIn (trigIn),
    .memRd (memRd), .memAddr (memAddr), .memData (memData),
    .tableReady (tableReady), .fixedValid (fixedValid), .fixedCode (fixedCode)
  );

  always @(posedge clk) if (memRd) memData <= mem[memAddr];

  always @(negedge clk) if (memRd) begin
    if (logN < 64) logA[logN] = int'(memAddr);
    logN++;
  end

  function automatic logic [31:0] mkSet(int id, bit imm, bit fix, int tgt);
    return {4'h1, 5'(id), imm, fix, 13'd0, 8'(tgt)};
  endfunction
  function automatic logic [31:0] mkMask(logic [27:0] m);
    return {4'h2, m};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkTrace(string tag, int n, trace_t e);
    chk({tag, " read count"}, logN, n);
    for (int i = 0; i < n && i < logN; i++) chk({tag, " read address"}, logA[i], e[i]);
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [27:0] v);
    @(negedge clk); trigIn = v;
    @(negedge clk); trigIn = '0;
  endtask

  task automatic waitRead(int addr);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (memRd && memAddr == 8'(addr)) break;
    end
  endtask

  task automatic clearMem;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  initial begin
    clearMem();
    // configuration A
    mem[0] = mkSet(3, 0, 0, 'h40);
    mem[1] = mkSet(1, 0, 0, 'h50);
    mem[2] = mkSet(0, 1, 0, 'h60);
    mem[3] = mkSet(27, 0, 0, 'h70);
    mem[4] = mkSet(5, 0, 1, 'hA5);
    mem[5] = mkMask(28'hFFF_FFFF);
    mem[6] = 32'hF000_0000;            // unknown opcode
    mem[7] = 32'h0;                    // END
    mem['h40] = 32'h3000_0000; mem['h41] = mkMask(28'hFFF_FFFF); mem['h42] = 32'h0;
    mem['h50] = 32'h3000_0000; mem['h51] = 32'h0;
    mem['h60] = 32'h0;
    mem['h70] = mkMask(28'h800_0008); mem['h71] = 32'h0;

    cycles(4);
    chk("R9 reset memRd", memRd, 0);
    chk("R9 reset tableReady", tableReady, 0);
    chk("R9 reset fixedValid", fixedValid, 0);
    rstN = 1'b1;
    cycles(2);

    logN = 0; activeEn = 1'b1; cycles(40);
    checkTrace("R1 R2 load pass", 8, '{0, 1, 2, 3, 4, 5, 6, 7});
    chk("R1 tableReady", tableReady, 1);

    logN = 0; pulse(28'h00A); cycles(30);
    checkTrace("R3 R4 priority", 5, '{'h50, 'h51, 'h40, 'h41, 'h42, 0, 0, 0});

    logN = 0; pulse(28'h008); waitRead('h40); pulse(28'h002); cycles(30);
    checkTrace("R5 deferred", 5, '{'h40, 'h41, 'h42, 'h50, 'h51, 0, 0, 0});

    logN = 0; pulse(28'h008); waitRead('h40);
    trigIn = 28'h001; @(negedge clk); trigIn = '0; cycles(20);
    checkTrace("R6 preempt", 2, '{'h40, 'h60, 0, 0, 0, 0, 0, 0});

    logN = 0; pulse(28'h800_0000); cycles(20);
    checkTrace("R7 enable-set seq", 2, '{'h70, 'h71, 0, 0, 0, 0, 0, 0});
    logN = 0; pulse(28'h002); cycles(20);
    chk("R7 disabled trigger ignored", logN, 0);
    pulse(28'h008); cycles(30);
    checkTrace("R7 latched served", 5, '{'h40, 'h41, 'h42, 'h50, 'h51, 0, 0, 0});

    logN = 0; @(negedge clk); trigIn = 28'h008; cycles(30); trigIn = '0; cycles(5);
    checkTrace("R10 held level", 3, '{'h40, 'h41, 'h42, 0, 0, 0, 0, 0});

    logN = 0; pulse(28'h020); cycles(10);
    chk("R8 fixedValid", fixedValid, 1);
    chk("R8 fixedCode", fixedCode, 'hA5);
    pulse(28'h002); cycles(10);
    chk("R8 no reads", logN, 0);
    chk("R8 still handed off", fixedValid, 1);

    activeEn = 1'b0; cycles(3);
    chk("R9 off fixedValid", fixedValid, 0);
    chk("R9 off tableReady", tableReady, 0);
    pulse(28'h002); cycles(2);

    // configuration B: every trigger deferred, target 0x80+id
    clearMem();
    for (int k = 0; k < 28; k++) mem[k] = mkSet(k, 0, 0, 'h80 + k);
    mem[28] = mkMask(28'hFFF_FFFF);
    logN = 0; activeEn = 1'b1; cycles(100);
    chk("R9 reload count, no stale pending", logN, 30);
    chk("R9 reload tableReady", tableReady, 1);

    for (int k = 0; k < 28; k++) begin
      logN = 0; pulse(28'(1) << k); cycles(8);
      checkTrace("R4 single sweep", 1, '{'h80 + k, 0, 0, 0, 0, 0, 0, 0});
      chk("R9 table rewritten no handoff", fixedValid, 0);
    end
    for (int i = 0; i < 28; i++) begin
      for (int j = i + 1; j < 28; j++) begin
        logN = 0; pulse((28'(1) << i) | (28'(1) << j)); cycles(10);
        checkTrace("R3 pair sweep", 2, '{'h80 + i, 'h80 + j, 0, 0, 0, 0, 0, 0});
      end
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nVec++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule